// File: doc/BRIEF.md
# Root-port interrupt status and mask controller

This block gathers the interrupt sources of a single root port into one 32-bit status word and drives a single summary interrupt towards the host. The lowest four source positions are the legacy level-sensitive lines INTA to INTD. They show the live input level and cannot be cleared by software. Every higher position is an edge event: its rising edge sets a sticky status bit, and that bit stays set until software writes a 1 to it.

Software reaches the block through a flat 32-bit register port with a write strobe and a separate combinational read address. A mask readback register shows which sources are blocked from the summary line. Two strobe registers change the mask: one sets mask bits under a write-1 pattern and the other clears them. The summary line is the registered OR of every status bit whose mask bit is clear. During initialisation, software writes all ones to the mask-set register and then all ones to the status register. This masks every source and discards every pending event.

Sources are assumed synchronous to the block clock. An edge is detected against a copy of the input delayed by one cycle. That copy resets to 0.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset the mask readback (offset 0x104) reads all ones, every event bit of status (offset 0x100) reads 0 and the summary output `irq` is 0.
- R2: A write to mask-set (offset 0x108) sets each mask bit whose data bit is 1. A write to mask-clear (offset 0x10C) clears each mask bit whose data bit is 1. Mask bits written with 0 keep their value. The new mask reads back at 0x104 on the cycle after the write.
- R3: Status bits 0 to 3 follow the live level of source inputs 0 to 3 in the same cycle. Writing 1 to those bits of the status register leaves them unchanged.
- R4: For each source bit from 4 to 31, a rising edge sets the status bit on the following clock edge. The bit holds until a write to status carries a 1 in that position. A write carrying 0 in that position leaves it set.
- R5: When a rising edge on an event source coincides with a write of 1 to that status bit, the bit is set after the clock edge.
- R6: `irq` goes high one clock after some status bit with a clear mask bit is 1. It goes low one clock after no such bit remains. A masked status bit never raises `irq`.
- R7: Reads of any offset other than 0x100 and 0x104 return 0, including the mask-set and mask-clear offsets. Writes to offsets other than 0x100, 0x108 and 0x10C change no state.
- R8: An event source that is held high sets its status bit only once. After software clears the bit, it stays 0 while the source remains high.
- R9: Writing all ones to mask-set and then all ones to status leaves the mask all ones and every event bit at 0, whatever events were pending. One clock later `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt sources; bits 0-3 level, the rest edge events |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write byte offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read byte offset |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The in-design assertions check on every cycle that a rising edge always leaves its sticky bit set, including when a clear write arrives in the same cycle. They also check that a pending bit survives while no clear is aimed at it, that set and clear strobes always land in the mask, and that a fully masked word keeps the summary line low. Some behaviours are visible only from the bench's sweeps over every source position. These are the live and uncleared behaviour of the four level lines, and the exact cycle in which `irq` rises and falls. They also include the zero readback of write-only and unmapped offsets, and the effect of the all-ones initialisation sequence on a mix of pending events.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PIRQ_AW = 12;

  localparam logic [PIRQ_AW-1:0] OFS_STATUS  = 12'h100;
  localparam logic [PIRQ_AW-1:0] OFS_MASK    = 12'h104;
  localparam logic [PIRQ_AW-1:0] OFS_MSK_SET = 12'h108;
  localparam logic [PIRQ_AW-1:0] OFS_MSK_CLR = 12'h10C;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_STATUS,
    ACC_MASK,
    ACC_MSK_SET,
    ACC_MSK_CLR
  } acc_e;

  function automatic acc_e decode_ofs(input logic [PIRQ_AW-1:0] ofs);
    case (ofs)
      OFS_STATUS:  decode_ofs = ACC_STATUS;
      OFS_MASK:    decode_ofs = ACC_MASK;
      OFS_MSK_SET: decode_ofs = ACC_MSK_SET;
      OFS_MSK_CLR: decode_ofs = ACC_MSK_CLR;
      default:     decode_ofs = ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pirq_regdec.sv
module pirq_regdec
  import pirq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = PIRQ_AW
) (
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [NSRC-1:0] stat_clr_o,
  output logic [NSRC-1:0] msk_set_o,
  output logic [NSRC-1:0] msk_clr_o
);
  acc_e wr_kind;

  always_comb begin
    wr_kind    = wr_en_i ? decode_ofs(wr_addr_i) : ACC_NONE;
    stat_clr_o = '0;
    msk_set_o  = '0;
    msk_clr_o  = '0;
    case (wr_kind)
      ACC_STATUS:  stat_clr_o = wr_data_i;
      ACC_MSK_SET: msk_set_o  = wr_data_i;
      ACC_MSK_CLR: msk_clr_o  = wr_data_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/pirq_capture.sv
module pirq_capture #(
  parameter int NSRC = 32,
  parameter int NLVL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] stat_clr_i,
  output logic [NSRC-1:0] status_o
);
  localparam logic [NSRC-1:0] EDGE_BITS = {{(NSRC-NLVL){1'b1}}, {NLVL{1'b0}}};

  function automatic logic [NSRC-1:0] rising(input logic [NSRC-1:0] cur,
                                            input logic [NSRC-1:0] prev);
    rising = cur & ~prev;
  endfunction

  function automatic logic [NSRC-1:0] sticky_next(input logic [NSRC-1:0] held,
                                                 input logic [NSRC-1:0] set_v,
                                                 input logic [NSRC-1:0] clr_v);
    sticky_next = (set_v | (held & ~clr_v)) & EDGE_BITS;
  endfunction

  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] sticky_q;
  logic [NSRC-1:0] rise_w;
  logic [NSRC-1:0] clr_w;

  assign rise_w = rising(src_i, src_q) & EDGE_BITS;
  assign clr_w  = stat_clr_i & EDGE_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      sticky_q <= '0;
    end else begin
      src_q    <= src_i;
      sticky_q <= sticky_next(sticky_q, rise_w, clr_w);
    end
  end

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    if (b < NLVL) begin : g_lvl
      assign status_o[b] = src_i[b];
    end else begin : g_edge
      assign status_o[b] = sticky_q[b];
    end
  end

  // R4, R5: an edge always leaves its bit set, even against a clear
  p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_w) |=> ((status_o & $past(rise_w)) == $past(rise_w)));

  // R4: a pending bit with no clear aimed at it holds
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sticky_q & ~clr_w)) |=> ((sticky_q & $past(sticky_q & ~clr_w)) == $past(sticky_q & ~clr_w)));

  // R4: without an edge, a cleared bit reads 0
  p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_w & ~rise_w)) |=> ((sticky_q & $past(clr_w & ~rise_w)) == '0));
endmodule

// File: rtl/pirq_mask.sv
module pirq_mask #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] mask_o
);
  function automatic logic [NSRC-1:0] mask_next(input logic [NSRC-1:0] cur,
                                               input logic [NSRC-1:0] s,
                                               input logic [NSRC-1:0] c);
    mask_next = (cur | s) & ~c;
  endfunction

  logic [NSRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_next(mask_q, set_i, clr_i);
  end

  assign mask_o = mask_q;

  // R2: set strobes land
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((mask_q & $past(set_i)) == $past(set_i)));

  // R2: clear strobes land
  p_clr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((mask_q & $past(clr_i)) == '0));

  // R2: no strobe, no change
  p_mask_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(mask_q));
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NLVL = 4,
  parameter int AW   = PIRQ_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [NSRC-1:0] rd_data_o,
  output logic            irq_o
);
  function automatic logic summary(input logic [NSRC-1:0] st,
                                   input logic [NSRC-1:0] mk);
    summary = |(st & ~mk);
  endfunction

  logic [NSRC-1:0] stat_clr_w;
  logic [NSRC-1:0] msk_set_w;
  logic [NSRC-1:0] msk_clr_w;
  logic [NSRC-1:0] status_w;
  logic [NSRC-1:0] mask_w;
  logic            pend_w;
  logic            irq_q;

  pirq_regdec #(.NSRC(NSRC), .AW(AW)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .stat_clr_o(stat_clr_w),
    .msk_set_o (msk_set_w),
    .msk_clr_o (msk_clr_w)
  );

  pirq_capture #(.NSRC(NSRC), .NLVL(NLVL)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .stat_clr_i(stat_clr_w),
    .status_o  (status_w)
  );

  pirq_mask #(.NSRC(NSRC)) u_msk (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (msk_set_w),
    .clr_i (msk_clr_w),
    .mask_o(mask_w)
  );

  assign pend_w = summary(status_w, mask_w);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_w;
  end

  assign irq_o = irq_q;

  always_comb begin
    case (decode_ofs(rd_addr_i))
      ACC_STATUS: rd_data_o = status_w;
      ACC_MASK:   rd_data_o = mask_w;
      default:    rd_data_o = '0;
    endcase
  end

  // R6: a fully masked word keeps the line low
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_w) |=> !irq_o);

  // R6: an unmasked pending bit raises the line next cycle
  p_pend_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_w & ~mask_w)) |=> irq_o);
endmodule

// File: tb/pirq_ctrl_tb_top.sv
module pirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic [11:0] rd_addr;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [31:0] bits);
    @(negedge clk);
    src = src | bits;
    @(negedge clk);
    src = src & ~bits;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(12'h100, d); check("R1 status", d, 32'h0);
    rd(12'h104, d); check("R1 mask", d, 32'hFFFF_FFFF);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R3 level lines
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); src[i] = 1'b1;
      rd(12'h100, d); check("R3 level follows", d, 32'd1 << i);
      wr(12'h100, 32'd1 << i);
      rd(12'h100, d); check("R3 clear ignored", d, 32'd1 << i);
      check("R6 masked level quiet", {31'd0, irq}, 32'd0);
      wr(12'h10C, 32'd1 << i);
      rd(12'h104, d); check("R2 mask clr", d, ~(32'd1 << i));
      tick(); check("R6 level raises irq", {31'd0, irq}, 32'd1);
      src[i] = 1'b0;
      rd(12'h100, d); check("R3 level drops", d, 32'h0);
      tick(); check("R6 irq drops", {31'd0, irq}, 32'd0);
      wr(12'h108, 32'd1 << i);
      rd(12'h104, d); check("R2 mask set", d, 32'hFFFF_FFFF);
    end

    // R4 edge events, every position
    for (int i = 4; i < 32; i++) begin
      pulse(32'd1 << i);
      rd(12'h100, d); check("R4 edge captured", d, 32'd1 << i);
      tick(); check("R6 masked event quiet", {31'd0, irq}, 32'd0);
      wr(12'h10C, 32'd1 << i);
      check("R6 not yet", {31'd0, irq}, 32'd0);
      tick(); check("R6 event raises irq", {31'd0, irq}, 32'd1);
      wr(12'h100, ~(32'd1 << i));
      rd(12'h100, d); check("R4 zero write keeps", d, 32'd1 << i);
      wr(12'h100, 32'd1 << i);
      rd(12'h100, d); check("R4 write1 clears", d, 32'h0);
      check("R6 irq lags clear", {31'd0, irq}, 32'd1);
      tick(); check("R6 irq falls", {31'd0, irq}, 32'd0);
      wr(12'h108, 32'd1 << i);
      rd(12'h104, d); check("R2 mask restored", d, 32'hFFFF_FFFF);
    end

    // R8 held-high source
    @(negedge clk); src[12] = 1'b1;
    tick();
    rd(12'h100, d); check("R8 set once", d, 32'h1000);
    wr(12'h100, 32'h1000);
    repeat (3) tick();
    rd(12'h100, d); check("R8 no reset while high", d, 32'h0);
    src[12] = 1'b0;
    tick();

    // R5 edge and clear in the same cycle
    pulse(32'h0040_0000);
    @(negedge clk);
    src[22] = 1'b1; wr_en = 1'b1; wr_addr = 12'h100; wr_data = 32'h0040_0000;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; src[22] = 1'b0;
    rd(12'h100, d); check("R5 edge wins", d, 32'h0040_0000);
    wr(12'h100, 32'h0040_0000);
    rd(12'h100, d); check("R5 later clear", d, 32'h0);

    // R7 unmapped offsets
    pulse(32'h8000_0000);
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    wr(12'h104, 32'h0);
    rd(12'h100, d); check("R7 status untouched", d, 32'h8000_0000);
    rd(12'h104, d); check("R7 mask untouched", d, 32'hFFFF_FFFF);
    rd(12'h110, d); check("R7 unmapped read", d, 32'h0);
    rd(12'h108, d); check("R7 set reads 0", d, 32'h0);
    rd(12'h10C, d); check("R7 clr reads 0", d, 32'h0);
    wr(12'h100, 32'hFFFF_FFFF);

    // R4 several edges at once, R9 init sequence
    pulse(32'h80DC_9870);
    rd(12'h100, d); check("R4 multi edge", d, 32'h80DC_9870);
    wr(12'h10C, 32'h0000_0F00);
    rd(12'h104, d); check("R2 partial clr", d, 32'hFFFF_F0FF);
    tick(); check("R6 partial unmask", {31'd0, irq}, 32'd1);
    wr(12'h10C, 32'hFFFF_FFFF);
    wr(12'h108, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); check("R9 all cleared", d, 32'h0);
    rd(12'h104, d); check("R9 all masked", d, 32'hFFFF_FFFF);
    tick(); check("R9 irq low", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule